// File: doc/BRIEF.md
# Dual-Format Stereo Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel samples. It runs directly on the incoming bit clock and watches a word-select (frame) clock and a single data line. A mode input picks one of two framings. In the delayed (I²S-style) framing, the first bit of a word follows each frame-clock change by one bit period, and a low frame clock marks the left channel. In the left-justified framing, the first bit arrives with the frame-clock change, and a high frame clock marks the left channel.

A width input sets how many bits of each half-frame form a sample, from 16 to 24. Bits are assembled most significant first into a 24-bit two's-complement word, and narrower samples are left-aligned. Bits that arrive after the sample is full are dropped. If a half-frame ends before the sample is full, the missing low bits read as zero. After the right channel of each stereo pair ends, the left and right words are updated together and a one-cycle strobe is raised. The bit clock may run at 32, 48, 64, 128 or 256 times the sample rate.

Top module: `dual_fmt_audio_rx`

## Requirements
- R1: All inputs are sampled on the rising bit-clock edge. Each sample is assembled most significant bit first, so the first captured bit of a half-frame lands in output bit 23.
- R2: With `fmt_lj` = 0 (delayed framing), the first sample bit is the one sampled one bit clock after the edge at which a frame-clock change is first seen. The bit sampled at that edge is the last bit of the preceding half-frame.
- R3: With `fmt_lj` = 1 (left-justified framing), the first sample bit is the one sampled at the edge where the frame-clock change is first seen. A frame clock at 1 marks left data and at 0 marks right data.
- R4: With `fmt_lj` = 0, a frame clock at 0 marks left data and at 1 marks right data.
- R5: `word_bits` sets the sample width. Values below 16 act as 16 and values above 24 act as 24. Output bits below the active width are zero.
- R6: Bits that arrive in a half-frame after the active width has been captured do not affect the output.
- R7: A half-frame shorter than the active width yields its captured bits left-aligned, with zeros in the missing low positions.
- R8: `pair_valid` is high for exactly one cycle, in the cycle after the edge that starts a new left half-frame (that edge ends the right half). `left_out` and `right_out` change only together with `pair_valid`.
- R9: A low `rst_n` at a rising edge clears both outputs and `pair_valid`. After reset, a pair is reported only if both its left half and its right half began with a detected frame-clock change.
- R10: Bit-clock ratios of 32, 48, 64, 128 and 256 per frame are received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_lj | input | 1 | 1 = left-justified framing, 0 = delayed (I²S-style) framing |
| word_bits | input | 5 | Requested sample width, clamped to 16..24 |
| frame_clk | input | 1 | Word-select clock; its level names the channel |
| sdata | input | 1 | Serial data, most significant bit first |
| left_out | output | 24 | Signed left sample, left-aligned |
| right_out | output | 24 | Signed right sample, left-aligned |
| pair_valid | output | 1 | One-cycle strobe when a new stereo pair is presented |

## Verification
The bench builds the block with its defaults: 24-bit outputs, a 16-bit minimum and a 5-bit width selector. This reaches every legal width, both clamp directions of the selector, and the widest left-aligned word. Directed frames at 32, 48, 64 and 256 bit clocks per frame exercise three cases: an exact fit in both framings, surplus bits set to 1 that must be dropped, and a 16-slot half-frame that is short for a 24-bit sample. A start in mid-frame after reset tests the suppression of the first, incomplete pair. The cycle in which the strobe appears is checked against the start of the following frame, separately for each framing.

// File: rtl/arx_pkg.sv
`timescale 1ns/1ps
package arx_pkg;

   typedef enum logic {
      FMT_DELAYED = 1'b0,
      FMT_LJUST   = 1'b1
   } arx_fmt_e;

   // Limit a requested width to the legal window.
   function automatic int arx_clamp(input int req, input int lo, input int hi);
      if (req < lo) return lo;
      if (req > hi) return hi;
      return req;
   endfunction

endpackage

// File: rtl/arx_frame_track.sv
`timescale 1ns/1ps
module arx_frame_track #(
   parameter int PRIME_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fmt_lj,
   input  logic frame_clk,
   output logic hf_start,
   output logic hf_left
);
   import arx_pkg::*;

   localparam int PW = $clog2(PRIME_CYC + 1);

   logic          fc_q, fc_qq;
   logic [PW-1:0] prime_cnt;
   logic          primed;
   logic          eff_now, eff_prev;
   arx_fmt_e      fmt;

   assign fmt = arx_fmt_e'(fmt_lj);

   // Frame-clock history follows the pin at all times.
   always_ff @(posedge clk) begin
      fc_q  <= frame_clk;
      fc_qq <= fc_q;
   end

   // History becomes trustworthy only after it has refilled post reset.
   always_ff @(posedge clk) begin
      if (!rst_n)
         prime_cnt <= '0;
      else if (prime_cnt != PW'(PRIME_CYC))
         prime_cnt <= prime_cnt + 1'b1;
   end

   assign primed = (prime_cnt == PW'(PRIME_CYC));

   // The delayed framing looks at the frame clock one bit late, which
   // turns it into left-justified timing against undelayed data.
   always_comb begin
      if (fmt == FMT_LJUST) begin
         eff_now  = frame_clk;
         eff_prev = fc_q;
         hf_left  = frame_clk;
      end else begin
         eff_now  = fc_q;
         eff_prev = fc_qq;
         hf_left  = ~fc_q;
      end
   end

   assign hf_start = primed && (eff_now != eff_prev);

endmodule

// File: rtl/arx_shift.sv
`timescale 1ns/1ps
module arx_shift #(
   parameter int OUT_W = 24,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hf_start,
   input  logic             sdata,
   input  logic [CNT_W-1:0] width_eff,
   output logic [OUT_W-1:0] word
);
   logic [CNT_W-1:0] cnt;
   logic [OUT_W-1:0] sr_nxt;
   logic             room;

   assign room = (cnt < width_eff);

   // Per-bit next-state: a fresh half starts with only its MSB set,
   // later bits land at the position the counter points to.
   for (genvar i = 0; i < OUT_W; i++) begin : g_bit
      localparam int POS = OUT_W - 1 - i;
      if (i == OUT_W - 1) begin : g_msb
         assign sr_nxt[i] = hf_start ? sdata : word[i];
      end else begin : g_rest
         assign sr_nxt[i] = hf_start ? 1'b0 :
                            (room && (cnt == CNT_W'(POS))) ? sdata : word[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word <= '0;
         cnt  <= '0;
      end else begin
         word <= sr_nxt;
         if (hf_start)
            cnt <= CNT_W'(1);
         else if (room)
            cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/arx_pair_out.sv
`timescale 1ns/1ps
module arx_pair_out #(
   parameter int OUT_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hf_start,
   input  logic                    hf_left,
   input  logic        [OUT_W-1:0] word,
   output logic signed [OUT_W-1:0] left_out,
   output logic signed [OUT_W-1:0] right_out,
   output logic                    pair_valid
);
   logic [OUT_W-1:0] left_hold;
   logic             half_ok;
   logic             half_is_left;
   logic             left_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_hold    <= '0;
         left_out     <= '0;
         right_out    <= '0;
         pair_valid   <= 1'b0;
         half_ok      <= 1'b0;
         half_is_left <= 1'b0;
         left_ok      <= 1'b0;
      end else begin
         pair_valid <= 1'b0;
         if (hf_start) begin
            // Close the half that just ended.
            if (half_ok && half_is_left) begin
               left_hold <= word;
               left_ok   <= 1'b1;
            end else if (half_ok && left_ok) begin
               left_out   <= left_hold;
               right_out  <= word;
               pair_valid <= 1'b1;
               left_ok    <= 1'b0;
            end
            half_ok      <= 1'b1;
            half_is_left <= hf_left;
         end
      end
   end

endmodule

// File: rtl/dual_fmt_audio_rx.sv
`timescale 1ns/1ps
module dual_fmt_audio_rx #(
   parameter int OUT_W  = 24,
   parameter int MIN_W  = 16,
   parameter int WSEL_W = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fmt_lj,
   input  logic [WSEL_W-1:0]        word_bits,
   input  logic                     frame_clk,
   input  logic                     sdata,
   output logic signed [OUT_W-1:0]  left_out,
   output logic signed [OUT_W-1:0]  right_out,
   output logic                     pair_valid
);
   import arx_pkg::*;

   localparam int CNT_W = $clog2(OUT_W + 1);

   if (MIN_W < 1 || MIN_W > OUT_W) begin : g_bad_min
      $error("MIN_W must lie in 1..OUT_W");
   end
   if ((1 << WSEL_W) <= OUT_W) begin : g_bad_sel
      $error("WSEL_W too narrow to request OUT_W");
   end

   logic             hf_start;
   logic             hf_left;
   logic [CNT_W-1:0] width_eff;
   logic [OUT_W-1:0] word;

   always_comb width_eff = CNT_W'(arx_clamp(int'(word_bits), MIN_W, OUT_W));

   arx_frame_track #(.PRIME_CYC(2)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .fmt_lj    (fmt_lj),
      .frame_clk (frame_clk),
      .hf_start  (hf_start),
      .hf_left   (hf_left)
   );

   arx_shift #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_sh (
      .clk       (clk),
      .rst_n     (rst_n),
      .hf_start  (hf_start),
      .sdata     (sdata),
      .width_eff (width_eff),
      .word      (word)
   );

   arx_pair_out #(.OUT_W(OUT_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .hf_start   (hf_start),
      .hf_left    (hf_left),
      .word       (word),
      .left_out   (left_out),
      .right_out  (right_out),
      .pair_valid (pair_valid)
   );

endmodule

// File: rtl/arx_chk.sv
`timescale 1ns/1ps
module arx_chk #(
   parameter int OUT_W = 24,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pair_valid,
   input logic [OUT_W-1:0] left_out,
   input logic [OUT_W-1:0] right_out,
   input logic             hf_start,
   input logic             hf_left,
   input logic [CNT_W-1:0] width_eff
);
   logic [OUT_W-1:0] low_mask;
   assign low_mask = ({OUT_W{1'b1}} >> width_eff);

   // R8
   pv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |=> !pair_valid);

   // R8
   pv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> $past(hf_start && hf_left));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pair_valid && $past(rst_n)) |-> ($stable(left_out) && $stable(right_out)));

   // R9
   reset_chk: assert property (@(posedge clk)
      !rst_n |=> (!pair_valid && left_out == '0 && right_out == '0));

   // R5
   pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> (((left_out | right_out) & low_mask) == '0));

endmodule

bind dual_fmt_audio_rx arx_chk #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pair_valid (pair_valid),
   .left_out   (left_out),
   .right_out  (right_out),
   .hf_start   (hf_start),
   .hf_left    (hf_left),
   .width_eff  (width_eff)
);

// File: tb/sim_dual_fmt_audio_rx.sv
`timescale 1ns/1ps
module sim_dual_fmt_audio_rx;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               fmt_lj = 1'b1;
   logic [4:0]         word_bits = 5'd24;
   logic               frame_clk = 1'b0;
   logic               sdata = 1'b0;
   logic signed [23:0] left_out, right_out;
   logic               pair_valid;

   int checks = 0;
   int fails  = 0;
   int pcnt   = 0;
   int ncap   = 0;
   logic [23:0] cap_l [16];
   logic [23:0] cap_r [16];
   int          cap_p [16];
   logic        carry = 1'b0;

   always #2.5 clk = ~clk;

   dual_fmt_audio_rx u0 (
      .clk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj), .word_bits(word_bits),
      .frame_clk(frame_clk), .sdata(sdata),
      .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid)
   );

   always @(posedge clk) pcnt++;

   always @(negedge clk) begin
      if (pair_valid && ncap < 16) begin
         cap_l[ncap] = left_out;
         cap_r[ncap] = right_out;
         cap_p[ncap] = pcnt;
         ncap++;
      end
   end

   initial begin
      #(5.0 * 200000);
      checks++; fails++;
      $display("FAIL watchdog: run did not end (actual hung, expected done)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] expect_word(input logic [23:0] src, input int n, input int w);
      int kept = (n < w) ? n : w;
      logic [23:0] m = 24'hFFFFFF << (24 - kept);
      return src & m;
   endfunction

   function automatic logic [23:0] pat(input int k, input int side);
      return 24'hA5C3E1 ^ (24'(k) * 24'h13579B) ^ (side ? 24'h5A0F96 : 24'h0);
   endfunction

   task automatic drive(input logic fc, input logic d);
      @(negedge clk);
      frame_clk = fc;
      sdata     = d;
   endtask

   // One frame, left half first; slots past the source word carry 1s.
   task automatic send_frame(input logic lj, input int n, input logic [23:0] l,
                             input logic [23:0] r, output int p0);
      p0 = -1;
      for (int h = 0; h < 2; h++) begin
         logic lv = lj ? (h == 0) : (h != 0);
         for (int j = 0; j < n; j++) begin
            logic b = (j < 24) ? (h == 0 ? l[23-j] : r[23-j]) : 1'b1;
            if (lj) drive(lv, b);
            else    drive(lv, carry);
            if (p0 < 0) p0 = pcnt;
            carry = b;
         end
      end
   endtask

   task automatic do_reset(input logic lj, input logic [4:0] wb, input logic start_level);
      rst_n = 1'b0; fmt_lj = lj; word_bits = wb;
      frame_clk = start_level; sdata = 1'b0; carry = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) drive(start_level, 1'b0);
      ncap = 0;
   endtask

   task automatic run_case(input string req, input logic lj, input logic [4:0] wb,
                           input int w_exp, input int n, input int nfr);
      int p0;
      logic [23:0] el, er;
      do_reset(lj, wb, lj ? 1'b0 : 1'b1);
      for (int k = 0; k < nfr; k++) send_frame(lj, n, pat(k, 0), pat(k, 1), p0);
      send_frame(lj, n, 24'h0, 24'h0, p0);
      chk({req, " pair count"}, ncap, nfr);
      for (int k = 0; k < nfr && k < ncap; k++) begin
         el = expect_word(pat(k, 0), n, w_exp);
         er = expect_word(pat(k, 1), n, w_exp);
         chk({req, " left"}, cap_l[k], el);
         chk({req, " right"}, cap_r[k], er);
      end
      // R8: strobe follows the flush frame start by one (LJ) or two cycles
      if (ncap > 0) chk({req, " R8 strobe cycle"}, cap_p[ncap-1], p0 + (lj ? 1 : 2));
   endtask

   task automatic t_reset_state;
      do_reset(1'b1, 5'd24, 1'b0);
      chk("R9 reset left", left_out, 0);
      chk("R9 reset right", right_out, 0);
      chk("R9 reset valid", pair_valid, 0);
   endtask

   task automatic t_lj_surplus;  run_case("R1 R3 R6 R10 lj 24b x64",  1'b1, 5'd24, 24, 32, 2); endtask
   task automatic t_i2s_exact;   run_case("R2 R4 i2s 24b x48",        1'b0, 5'd24, 24, 24, 2); endtask
   task automatic t_i2s_tight;   run_case("R2 R10 i2s 16b x32",       1'b0, 5'd16, 16, 16, 2); endtask
   task automatic t_lj_width18;  run_case("R5 lj 18b x48",            1'b1, 5'd18, 18, 24, 1); endtask
   task automatic t_lj_short;    run_case("R7 lj 24b x32 short",      1'b1, 5'd24, 24, 16, 2); endtask
   task automatic t_i2s_wide;    run_case("R6 R10 i2s 20b x256",      1'b0, 5'd20, 20, 128, 1); endtask
   task automatic t_clamp_hi;    run_case("R5 clamp high 31",         1'b1, 5'd31, 24, 32, 1); endtask
   task automatic t_clamp_lo;    run_case("R5 clamp low 3",           1'b0, 5'd3,  16, 32, 1); endtask

   task automatic t_midframe;
      int p0;
      do_reset(1'b1, 5'd24, 1'b1);
      send_frame(1'b1, 32, pat(7, 0), pat(7, 1), p0);
      send_frame(1'b1, 32, pat(8, 0), pat(8, 1), p0);
      send_frame(1'b1, 32, 24'h0, 24'h0, p0);
      chk("R9 midframe pair count", ncap, 1);
      chk("R9 midframe left", cap_l[0], pat(8, 0));
      chk("R9 midframe right", cap_r[0], pat(8, 1));
      repeat (5) @(negedge clk);
      chk("R8 outputs held", left_out, pat(8, 0));
   endtask

   initial begin
      t_reset_state;
      t_lj_surplus;
      t_i2s_exact;
      t_i2s_tight;
      t_lj_width18;
      t_lj_short;
      t_i2s_wide;
      t_clamp_hi;
      t_clamp_lo;
      t_midframe;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule